// File: doc/BRIEF.md
# Calendar Clock with Alarm and Periodic Interrupts

This block keeps seconds, minutes, hours, weekday, date, month and two-digit year in a fourteen-entry register file that a host reaches over a small parallel bus with chip select, write strobe, read strobe, a four-bit address and byte-wide data. A once-per-second strobe from an outside prescaler starts an update. A busy flag goes up first as a warning. After a fixed lead time the whole date advances in one step. The clock then checks the new time against three alarm bytes.

Software picks binary or BCD storage and 12- or 24-hour form through the control byte. It can freeze updates so that it can load a new time. Three event flags report a periodic rate event, an alarm match and a finished update. The event flags clear when the host reads them. An interrupt line shows whether any flag whose enable is set is pending. The periodic rate also drives a square-wave pin.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the clock reads 00:00:00, weekday 1, date 01/01/00, alarm bytes 0x00, rate byte (addr 10) 0x00, control (addr 11) 0x02 (24-hour, BCD), flags (addr 12) 0x00, and irq and sqw are low.
- R2: Addresses 0–9 hold sec, sec-alarm, min, min-alarm, hour, hour-alarm, weekday, date, month and year, and they read back what was written. At addr 10, bit 7 is the read-only busy flag and bits 6:0 are writable. Writes to addr 12 and addr 13 are ignored, and addr 13 always reads 0x80.
- R3: With control bit 7 clear, a tick raises busy (addr 10 bit 7) on the next cycle. Busy stays high for LEAD_CYC cycles. The time registers change on the edge where busy falls, and that same edge sets the update flag (addr 12 bit 4).
- R4: While control bit 7 is set, ticks are ignored and an update already pending is dropped. Busy stays low and the time registers keep the values that were written.
- R5: In BCD mode (control bit 2 = 0), the seconds advance with decimal digit carry (0x09→0x10). A count of 59 seconds wraps to 0x00 and carries into the minutes, then the hours (23→00), then the date.
- R6: In binary mode (control bit 2 = 1), every field counts in plain binary (0x09→0x0A, 0x3B→0x00 with carry).
- R7: In 12-hour mode (control bit 1 = 0), hours run from 1 to 12 with bit 7 meaning PM: 11 AM→0x92 (12 PM), 12 PM→0x81, and 11 PM→0x12 (12 AM) with a day advance.
- R8: The date wraps at the month's length (30 days for months 4, 6, 9 and 11, 31 for the others, and 29 for February when the year mod 4 = 0, otherwise 28). The month wraps 12→1 and the year wraps 99→00. The weekday runs 1..7 and wraps from 7 to 1.
- R9: At the end of an update the alarm flag (addr 12 bit 5) is set when the new seconds, minutes and hours each equal their alarm byte. An alarm byte with bits 7:6 = 11 matches any value.
- R10: Addr 12 bit 7 is set when any flag has its enable set. The enables are control bit 6 for the periodic flag (bit 6), control bit 5 for the alarm flag (bit 5) and control bit 4 for the update flag (bit 4). The irq output follows that bit. A read of addr 12 returns the flags and then clears all of them.
- R11: Let r be the value of rate bits 3:0 at addr 10. When r ≠ 0, the periodic flag is set every 2^r clock cycles; when r = 0 it is never set. When control bit 3 is set and r ≠ 0, sqw is a square wave with a period of 2^r cycles; otherwise sqw stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse, once per second |
| cs | input | 1 | Bus select |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe (clears the flags at addr 12) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Interrupt request, active high |
| sqw | output | 1 | Square-wave output |

## Verification
A table of starting dates drives the update step. It uses plain second steps, BCD digit carries, the full year-end rollover, leap and non-leap February, 30- and 31-day months, binary storage, and the three 12-hour crossings. Each entry checks a different carry path or encoding. The update timing is traced one cycle at a time, which separates a late or early busy flag from a late change of the time registers. Exact, mismatched and wildcard alarm bytes show whether the compare uses the new time and honours the wildcard. Periodic and square-wave runs at one rate, and at rate zero, check the divider tap and its disable.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int LEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cs,
  input  logic       we,
  input  logic       re,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       sqw
);
  localparam int CW = $clog2(LEAD_CYC + 1);
  localparam int PW = 16;

  logic [7:0]    tm [0:9];
  logic [6:0]    a_q;
  logic [7:0]    b_q;
  logic [2:0]    c_q;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pc_q;

  function automatic logic [6:0] dec(input logic [7:0] v, input logic bin);
    return bin ? v[6:0] : 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] n, input logic bin);
    return bin ? {1'b0, n} : {4'(n / 7'd10), 4'(n % 7'd10)};
  endfunction

  function automatic logic hit(input logic [7:0] al, input logic [7:0] cur);
    return (al[7:6] == 2'b11) || (al == cur);
  endfunction

  wire bin  = b_q[2];
  wire m24  = b_q[1];
  wire wr   = cs && we;
  wire rd_c = cs && re && addr == 4'd12;
  wire upd_fire = busy && cnt == '0 && !b_q[7];

  logic [6:0] s, mi, hl, h24, dw, dm, mo, yr, dim;
  logic [6:0] ns, nmi, nh, ndw, ndm, nmo, nyr, h12;
  logic       c1, c2, c3, c4, c5;
  logic [7:0] nx_s, nx_m, nx_h;

  always_comb begin
    s   = dec(tm[0], bin);
    mi  = dec(tm[2], bin);
    hl  = dec({1'b0, tm[4][6:0]}, bin);
    dw  = dec(tm[6], bin);
    dm  = dec(tm[7], bin);
    mo  = dec(tm[8], bin);
    yr  = dec(tm[9], bin);
    h24 = m24 ? hl : ((hl == 7'd12) ? 7'd0 : hl) + (tm[4][7] ? 7'd12 : 7'd0);
    case (mo)
      7'd2:                       dim = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    dim = 7'd30;
      default:                    dim = 7'd31;
    endcase
    c1  = s >= 7'd59;
    ns  = c1 ? 7'd0 : s + 7'd1;
    c2  = c1 && mi >= 7'd59;
    nmi = c1 ? (c2 ? 7'd0 : mi + 7'd1) : mi;
    c3  = c2 && h24 >= 7'd23;
    nh  = c2 ? (c3 ? 7'd0 : h24 + 7'd1) : h24;
    ndw = c3 ? (dw >= 7'd7 ? 7'd1 : dw + 7'd1) : dw;
    c4  = c3 && dm >= dim;
    ndm = c3 ? (c4 ? 7'd1 : dm + 7'd1) : dm;
    c5  = c4 && mo >= 7'd12;
    nmo = c4 ? (c5 ? 7'd1 : mo + 7'd1) : mo;
    nyr = c5 ? (yr >= 7'd99 ? 7'd0 : yr + 7'd1) : yr;
    h12 = (nh % 7'd12 == 7'd0) ? 7'd12 : nh % 7'd12;
    nx_s = enc(ns, bin);
    nx_m = enc(nmi, bin);
    nx_h = m24 ? enc(nh, bin) : (enc(h12, bin) | {nh >= 7'd12, 7'b0});
  end

  wire af_evt = upd_fire && hit(tm[1], nx_s) && hit(tm[3], nx_m) && hit(tm[5], nx_h);

  wire [3:0]    rate  = a_q[3:0];
  wire [PW-1:0] pmask = (PW'(1) << rate) - PW'(1);
  wire          pevt  = rate != 4'd0 && (pc_q & pmask) == pmask;

  assign sqw = b_q[3] && rate != 4'd0 && pc_q[rate - 4'd1];
  wire irqf = |(c_q & b_q[6:4]);
  assign irq = irqf;

  always_comb begin
    case (addr)
      4'd10:   rdata = {busy, a_q};
      4'd11:   rdata = b_q;
      4'd12:   rdata = {irqf, c_q, 4'b0};
      4'd13:   rdata = 8'h80;
      4'd14, 4'd15: rdata = 8'h00;
      default: rdata = tm[addr];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 10; i++) tm[i] <= 8'h00;
      tm[6] <= 8'h01;
      tm[7] <= 8'h01;
      tm[8] <= 8'h01;
      a_q   <= '0;
      b_q   <= 8'h02;
    end else begin
      if (wr && addr < 4'd10) tm[addr] <= wdata;
      if (wr && addr == 4'd10) a_q <= wdata[6:0];
      if (wr && addr == 4'd11) b_q <= wdata;
      if (upd_fire) begin
        tm[0] <= nx_s;
        tm[2] <= nx_m;
        tm[4] <= nx_h;
        tm[6] <= enc(ndw, bin);
        tm[7] <= enc(ndm, bin);
        tm[8] <= enc(nmo, bin);
        tm[9] <= enc(nyr, bin);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (b_q[7]) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (tick) begin
        busy <= 1'b1;
        cnt  <= CW'(LEAD_CYC - 1);
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q  <= '0;
      pc_q <= '0;
    end else begin
      pc_q <= pc_q + 1'b1;
      if (rd_c) c_q <= '0;
      if (pevt) c_q[2] <= 1'b1;
      if (af_evt) c_q[1] <= 1'b1;
      if (upd_fire) c_q[0] <= 1'b1;
    end
  end

  assert_sec_moves_on_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tm[0]) |-> ($past(upd_fire) || $past(wr && addr == 4'd0)));

  assert_uip_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(upd_fire) || $past(b_q[7])));

  assert_set_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    b_q[7] |=> !busy);

  assert_alarm_flag_at_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_q[1]) |-> $past(upd_fire));

  assert_read_clears_c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !upd_fire && !pevt) |=> c_q == 3'b000);

  assert_irq_drops_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(rd_c || (wr && addr == 4'd11)));
endmodule

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/10ps
module rtc_calendar_tb;
  localparam int LEAD = 4;
  localparam int NV = 14;
  // {ctrl, s, m, h, wday, date, mon, yr, then expected s, m, h, wday, date, mon, yr}
  localparam logic [119:0] VEC [NV] = '{
    120'h02_00_00_00_01_01_01_00_01_00_00_01_01_01_00,
    120'h02_59_59_23_07_31_12_99_00_00_00_01_01_01_00,
    120'h02_59_59_23_03_28_02_23_00_00_00_04_01_03_23,
    120'h02_59_59_23_03_28_02_24_00_00_00_04_29_02_24,
    120'h02_59_59_23_04_29_02_24_00_00_00_05_01_03_24,
    120'h02_59_59_23_02_30_04_24_00_00_00_03_01_05_24,
    120'h02_59_59_23_02_30_01_24_00_00_00_03_31_01_24,
    120'h02_09_15_08_02_10_05_24_10_15_08_02_10_05_24,
    120'h06_3B_3B_17_02_1F_01_0A_00_00_00_03_01_02_0A,
    120'h06_09_00_00_01_01_01_00_0A_00_00_01_01_01_00,
    120'h00_59_59_11_01_01_01_00_00_00_92_01_01_01_00,
    120'h00_59_59_92_01_01_01_00_00_00_81_01_01_01_00,
    120'h00_59_59_91_05_15_06_20_00_00_12_06_16_06_20,
    120'h04_3B_3B_8B_01_01_01_00_00_00_0C_02_02_01_00
  };
  localparam logic [3:0] TADDR [7] = '{4'd0, 4'd2, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9};

  logic clk = 0, rst_n = 0, tick = 0, cs = 0, we = 0, re = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq, sqw;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  rtc_calendar #(.LEAD_CYC(LEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .we(we), .re(re),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .sqw(sqw));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; cs = 1; we = 1;
    step();
    cs = 0; we = 0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    addr = a; #0.1; v = rdata;
  endtask

  task automatic rdc(output logic [7:0] v);
    addr = 4'd12; cs = 1; re = 1; #0.1; v = rdata;
    step();
    cs = 0; re = 0;
  endtask

  task automatic pulse();
    tick = 1;
    step();
    tick = 0;
  endtask

  task automatic set_time(input logic [7:0] ctrl, input logic [7:0] s,
                          input logic [7:0] m, input logic [7:0] h);
    wr(4'd11, ctrl | 8'h80);
    wr(4'd0, s); wr(4'd2, m); wr(4'd4, h);
    wr(4'd11, ctrl);
  endtask

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    logic [55:0] act, exp;
    int highs;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();

    // R1 reset state
    for (int a = 0; a < 14; a++) begin
      logic [7:0] e;
      case (a)
        6, 7, 8: e = 8'h01;
        11:      e = 8'h02;
        13:      e = 8'h80;
        default: e = 8'h00;
      endcase
      peek(4'(a), v);
      chk($sformatf("R1 reset addr %0d", a), {56'h0, v}, {56'h0, e});
    end
    chk("R1 irq/sqw after reset", {62'h0, irq, sqw}, 64'h0);

    // R5 R6 R7 R8 table of update vectors
    for (int i = 0; i < NV; i++) begin
      logic [7:0] ctrl;
      string tag;
      ctrl = VEC[i][119:112];
      tag = ctrl[2] ? "R6" : !ctrl[1] ? "R7" : (i >= 1 && i <= 6) ? "R8" : "R5";
      wr(4'd11, ctrl | 8'h80);
      for (int k = 0; k < 7; k++) wr(TADDR[k], VEC[i][111 - 8*k -: 8]);
      wr(4'd11, ctrl);
      rdc(v);
      pulse();
      repeat (LEAD) step();
      for (int k = 0; k < 7; k++) begin
        peek(TADDR[k], v);
        act[55 - 8*k -: 8] = v;
      end
      exp = VEC[i][55:0];
      chk($sformatf("%s vector %0d", tag, i), {8'h0, act}, {8'h0, exp});
      peek(4'd12, v);
      chk($sformatf("R3 update flag vector %0d", i), {63'h0, v[4]}, 64'h1);
    end

    // R2 register access
    wr(4'd1, 8'h5A); wr(4'd3, 8'hA5); wr(4'd5, 8'h3C);
    peek(4'd1, v); chk("R2 sec alarm readback", {56'h0, v}, 64'h5A);
    peek(4'd3, v); chk("R2 min alarm readback", {56'h0, v}, 64'hA5);
    peek(4'd5, v); chk("R2 hour alarm readback", {56'h0, v}, 64'h3C);
    wr(4'd13, 8'h00);
    peek(4'd13, v); chk("R2 addr13 fixed", {56'h0, v}, 64'h80);
    rdc(v);
    wr(4'd12, 8'hFF);
    peek(4'd12, v); chk("R2 addr12 write ignored", {56'h0, v}, 64'h00);
    wr(4'd10, 8'hFF);
    peek(4'd10, v); chk("R2 busy bit read-only", {56'h0, v}, 64'h7F);
    wr(4'd10, 8'h00);
    rdc(v);

    // R3 cycle timing of busy and time change
    set_time(8'h02, 8'h10, 8'h00, 8'h00);
    rdc(v);
    pulse();
    for (int k = 0; k < LEAD; k++) begin
      peek(4'd10, v); peek(4'd0, v2);
      chk($sformatf("R3 busy/time cycle %0d", k), {48'h0, v[7], 7'h0, v2}, {48'h0, 8'h80, 8'h10});
      step();
    end
    peek(4'd10, v); peek(4'd0, v2);
    chk("R3 busy falls with time change", {48'h0, v[7], 7'h0, v2}, {48'h0, 8'h00, 8'h11});

    // R4 SET freezes updates and aborts a pending one
    wr(4'd11, 8'h82);
    wr(4'd0, 8'h30);
    pulse();
    peek(4'd10, v); chk("R4 busy stays low under SET", {63'h0, v[7]}, 64'h0);
    repeat (LEAD + 2) step();
    peek(4'd0, v); chk("R4 time held under SET", {56'h0, v}, 64'h30);
    wr(4'd11, 8'h02);
    pulse();
    wr(4'd11, 8'h82);
    repeat (LEAD + 2) step();
    peek(4'd0, v); peek(4'd10, v2);
    chk("R4 pending update aborted", {48'h0, v, v2[7], 7'h0}, {48'h0, 8'h30, 8'h00});
    wr(4'd11, 8'h02);

    // R9 alarm compare
    wr(4'd1, 8'h45); wr(4'd3, 8'h30); wr(4'd5, 8'h12);
    set_time(8'h02, 8'h44, 8'h30, 8'h12);
    rdc(v); pulse(); repeat (LEAD) step();
    peek(4'd12, v); chk("R9 exact alarm match", {56'h0, v}, 64'h30);
    wr(4'd1, 8'h50);
    set_time(8'h02, 8'h44, 8'h30, 8'h12);
    rdc(v); pulse(); repeat (LEAD) step();
    peek(4'd12, v); chk("R9 no match", {56'h0, v}, 64'h10);
    wr(4'd1, 8'hC0); wr(4'd3, 8'hC0); wr(4'd5, 8'hFF);
    set_time(8'h02, 8'h19, 8'h07, 8'h05);
    rdc(v); pulse(); repeat (LEAD) step();
    peek(4'd12, v); chk("R9 wildcard match", {56'h0, v}, 64'h30);
    chk("R10 irq low without enables", {63'h0, irq}, 64'h0);

    // R10 interrupt gating and clear on read
    wr(4'd11, 8'h22);
    peek(4'd12, v); chk("R10 flag summary bit", {56'h0, v}, 64'hB0);
    chk("R10 irq with alarm enable", {63'h0, irq}, 64'h1);
    rdc(v); chk("R10 read returns flags", {56'h0, v}, 64'hB0);
    peek(4'd12, v); chk("R10 flags cleared by read", {56'h0, v}, 64'h00);
    chk("R10 irq cleared by read", {63'h0, irq}, 64'h0);
    wr(4'd11, 8'h02);

    // R11 periodic flag and square wave
    wr(4'd11, 8'h42);
    wr(4'd10, 8'h02);
    rdc(v);
    repeat (6) step();
    peek(4'd12, v); chk("R11 periodic flag at rate 2", {56'h0, v}, 64'hC0);
    chk("R11 irq from periodic", {63'h0, irq}, 64'h1);
    wr(4'd11, 8'h0A);
    highs = 0;
    for (int k = 0; k < 8; k++) begin
      highs += int'(sqw);
      step();
    end
    chk("R11 square wave duty over 8 cycles", 64'(highs), 64'd4);
    wr(4'd11, 8'h02);
    highs = 0;
    for (int k = 0; k < 8; k++) begin
      highs += int'(sqw);
      step();
    end
    chk("R11 square wave off without enable", 64'(highs), 64'd0);
    wr(4'd10, 8'h00);
    rdc(v);
    repeat (40) step();
    peek(4'd12, v); chk("R11 rate zero sets no flag", {56'h0, v}, 64'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule